// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small nonvolatile memory reached over a three-wire serial link. The link has a select line (`cs`), a serial clock (`sk`) and a data input (`di`), plus one data output that the block either drives or releases. All three link inputs are sampled with the system clock. A rising edge of `sk` while `cs` is high shifts one bit in. The store holds 2048 bits. A static `org` input chooses between two shapes: 128 words of 16 bits, or 256 words of 8 bits.

A host first sends a start bit. It then sends a two-bit command code and an address, and for the store commands the data, MSB first. Commands that change the store take effect when `cs` falls. A self-timed busy period follows, lasting a parameterised number of system clocks. During that period the output reports progress whenever the host raises `cs`. The output is released on the rising `sk` edge that shifts in a 1. The data input and the output can therefore share one wire.

Top module: `uwire_eeprom`

## Requirements
- R1: A bit is taken from `di` only on a rising `sk` edge while `cs` is high. Zeros shifted in before the first 1 are ignored, and that first 1 is the start bit.
- R2: With `org`=1 the frame after the start bit is a 2-bit code followed by a 7-bit address, and data words are 16 bits. Codes: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 extended. In the extended group the two address MSBs select 2'b11 enable, 2'b00 disable, 2'b10 erase-all and 2'b01 write-all.
- R3: With `org`=0 the address is 8 bits and data words are 8 bits, with the same codes and the same extended selectors in the two address MSBs.
- R4: A read drives `do_o`=0 with `do_en`=1 after the last address bit. Each following rising `sk` then presents the next data bit, MSB first. The rising `sk` after the last data bit sets `do_en` to 0.
- R5: Write, erase, write-all and erase-all have no effect unless the enable command was given. Reset and the disable command both clear the enable.
- R6: Erase sets the addressed word to all ones. Erase-all sets every word to all ones.
- R7: Write-all stores the shifted-in data word at every address.
- R8: A store command commits only when `cs` falls after its last bit. If `cs` falls earlier, the command is dropped and no busy period starts.
- R9: A commit starts a busy period of `BUSY_CLKS` system clocks. During that period, raising `cs` gives `do_en`=1 and `do_o`=0, and after it `do_o`=1. Start bits are ignored while busy.
- R10: While `cs` is high, a rising `sk` with `di`=1 ends the status display and sets `do_en` to 0.
- R11: `do_en` is 0 whenever `cs` is low. It is also 0 with `cs` high unless a read is shifting out or a status report is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| org | input | 1 | Word shape: 1 for 16-bit, 0 for 8-bit |
| cs | input | 1 | Select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Write cut short by an early `cs` fall:** a design that committed on the last bit seen would corrupt the word and start a busy period.
- **Second write sent while busy:** a design that did not ignore start bits during the busy period would overwrite the first value.
- **Store commands after disable and after reset:** a design that left the enable set would change data that must stay unchanged.
- **Read framing and status release:** the bench checks the leading dummy 0 and the release one edge after the last data bit, so an off-by-one in the read sequence shifts every bit it reads. It also checks that a shifted-in 1 releases the status drive, so a design that missed this would hold a shared data wire.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int BUSY_CLKS = 400,
  parameter int BYTES     = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_en
);
  localparam int AW8  = $clog2(BYTES);
  localparam int AW16 = AW8 - 1;
  localparam int CW   = $clog2(BUSY_CLKS + 1);
  localparam logic [1:0] OP_EXT = 2'b00, OP_WR = 2'b01, OP_RD = 2'b10, OP_ER = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RD, S_DATA, S_ARM, S_DONE} st_t;
  typedef enum logic [1:0] {K_WR, K_WRAL, K_ER, K_ERAL} kind_t;

  logic [7:0]    mem [BYTES];
  st_t           st;
  kind_t         kind;
  logic          sk_d, cs_d, wen, rd_on, rd_bit, stat_pend;
  logic [4:0]    cnt;
  logic [AW8:0]  sh;
  logic [AW8-1:0] addr;
  logic [15:0]   dsh;
  logic [CW-1:0] bcnt;

  wire rise    = cs & sk & ~sk_d;
  wire cs_fall = cs_d & ~cs;
  wire busy    = bcnt != '0;
  wire commit  = cs_fall && st == S_ARM && wen;

  logic [4:0] aw, dw;
  assign aw = org ? 5'(AW16) : 5'(AW8);
  assign dw = org ? 5'd16 : 5'd8;

  logic [AW8+1:0] nsh;
  logic [1:0]     op_n, ext_n;
  logic [AW8-1:0] ad_n;
  logic [15:0]    rd_word;
  assign nsh   = {sh, di};
  assign op_n  = org ? nsh[AW16+1:AW16] : nsh[AW8+1:AW8];
  assign ext_n = org ? nsh[AW16-1:AW16-2] : nsh[AW8-1:AW8-2];
  assign ad_n  = org ? {1'b0, nsh[AW16-1:0]} : nsh[AW8-1:0];
  assign rd_word = org ? {mem[{ad_n[AW16-1:0], 1'b0}], mem[{ad_n[AW16-1:0], 1'b1}]}
                       : {mem[ad_n], 8'h00};

  assign do_en = cs & (rd_on | stat_pend);
  assign do_o  = rd_on ? rd_bit : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_WR; sk_d <= 1'b0; cs_d <= 1'b0; wen <= 1'b0;
      rd_on <= 1'b0; rd_bit <= 1'b0; stat_pend <= 1'b0; cnt <= '0;
      sh <= '0; addr <= '0; dsh <= '0; bcnt <= '0;
    end else begin
      sk_d <= sk;
      cs_d <= cs;
      if (busy) bcnt <= bcnt - 1'b1;
      if (rise && di) stat_pend <= 1'b0;
      if (!cs) begin
        st    <= S_IDLE;
        rd_on <= 1'b0;
        if (commit) begin
          bcnt      <= CW'(BUSY_CLKS);
          stat_pend <= 1'b1;
        end
      end else if (rise) begin
        case (st)
          S_IDLE: if (di && !busy) begin
            st  <= S_CMD;
            cnt <= '0;
            sh  <= '0;
          end
          S_CMD: begin
            sh  <= nsh[AW8:0];
            cnt <= cnt + 1'b1;
            if (cnt == aw + 5'd1) begin
              addr <= ad_n;
              cnt  <= '0;
              dsh  <= '0;
              case (op_n)
                OP_RD: begin st <= S_RD; rd_on <= 1'b1; rd_bit <= 1'b0; dsh <= rd_word; end
                OP_WR: begin st <= S_DATA; kind <= K_WR; end
                OP_ER: begin st <= S_ARM; kind <= K_ER; end
                default: case (ext_n)
                  2'b11:   begin wen <= 1'b1; st <= S_DONE; end
                  2'b00:   begin wen <= 1'b0; st <= S_DONE; end
                  2'b10:   begin kind <= K_ERAL; st <= S_ARM; end
                  default: begin kind <= K_WRAL; st <= S_DATA; end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dsh <= {dsh[14:0], di};
            cnt <= cnt + 1'b1;
            if (cnt == dw - 5'd1) st <= S_ARM;
          end
          S_RD: begin
            if (cnt == dw) begin
              rd_on <= 1'b0;
              st    <= S_DONE;
            end else begin
              rd_bit <= dsh[15];
              dsh    <= {dsh[14:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      case (kind)
        K_WR:
          if (org) begin
            mem[{addr[AW16-1:0], 1'b0}] <= dsh[15:8];
            mem[{addr[AW16-1:0], 1'b1}] <= dsh[7:0];
          end else mem[addr] <= dsh[7:0];
        K_ER:
          if (org) begin
            mem[{addr[AW16-1:0], 1'b0}] <= 8'hFF;
            mem[{addr[AW16-1:0], 1'b1}] <= 8'hFF;
          end else mem[addr] <= 8'hFF;
        K_ERAL:
          for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
        default:
          for (int i = 0; i < BYTES; i++)
            mem[i] <= (org && !i[0]) ? dsh[15:8] : dsh[7:0];
      endcase
    end
  end

  a_r11_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_en);
  a_r9_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bcnt == $past(bcnt) - 1'b1);
  a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs && st == S_IDLE) |=> st == S_IDLE);
  a_r4_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_on) |-> !do_o);
  a_r10_one_releases_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && di) |=> !stat_pend);
  a_r5_locked_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && st == S_ARM && !wen) |=> !busy);
endmodule

// File: tb/uwire_eeprom_tb.sv
module uwire_eeprom_tb;
  localparam int BUSY = 400;
  logic clk = 0, rst_n = 0, org = 1, cs = 0, sk = 0, di = 0;
  logic do_o, do_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] rv;

  uwire_eeprom #(.BUSY_CLKS(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .org(org), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_en(do_en));

  always #5 clk = ~clk;

  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'hA5C3}, {8'h7F, 16'h0001}, {8'h2A, 16'h8000},
    {8'h15, 16'hFFFE}, {8'h40, 16'h1234}, {8'h01, 16'h0F0F}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    di = b; clks(3); sk = 1; clks(4); sk = 0; clks(1);
  endtask

  task automatic send(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic sel();   cs = 1; clks(2); endtask
  task automatic desel(); cs = 0; di = 0; clks(3); endtask

  function automatic int aw(); return org ? 7 : 8; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  task automatic instr(logic [1:0] op, logic [7:0] a, int lead);
    sel();
    send(0, lead);
    bit_out(1);
    send(op, 2);
    send(a, aw());
  endtask

  task automatic ext(logic [1:0] s);
    instr(2'b00, org ? {1'b0, s, 5'b0} : {s, 6'b0}, 0);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    instr(2'b01, a, 0); send(d, dw()); desel();
  endtask

  task automatic wait_ready(string req);
    int k = 0;
    sel();
    while (do_o !== 1'b1 && k < 5000) begin clks(1); k++; end
    chk(req, do_o, 1);
    desel();
  endtask

  task automatic rd(logic [7:0] a, int lead, string req, output logic [15:0] d);
    instr(2'b10, a, lead);
    chk({req, " dummy"}, {do_en, do_o}, 2'b10);
    d = 0;
    for (int i = 0; i < dw(); i++) begin
      bit_out(0);
      d = {d[14:0], do_o};
    end
    bit_out(0);
    chk({req, " release"}, do_en, 0);
    desel();
  endtask

  task automatic do_reset();
    rst_n = 0; clks(5); rst_n = 1; clks(2);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    sel(); chk("R11 reset idle drive", do_en, 0); desel();

    ext(2'b11); desel();
    wr(8'h10, 16'h1111); wait_ready("R9 first write ready");
    ext(2'b00); desel();
    wr(8'h10, 16'h2222);
    sel(); chk("R5 locked write no status", do_en, 0); desel();
    rd(8'h10, 0, "R5 locked write", rv); chk("R5 locked write data", rv, 16'h1111);
    do_reset();
    wr(8'h10, 16'h3333);
    rd(8'h10, 0, "R5 reset lock", rv); chk("R5 reset clears enable", rv, 16'h1111);

    ext(2'b11); desel();
    foreach (VEC[i]) begin
      wr(VEC[i][23:16], VEC[i][15:0]);
      wait_ready("R9 table write");
    end
    foreach (VEC[i]) begin
      rd(VEC[i][23:16], 0, "R4 table read", rv);
      chk("R2 table word", rv, {16'h0, VEC[i][15:0]});
    end

    wr(8'h20, 16'h5555);
    sel();
    chk("R9 busy status", {do_en, do_o}, 2'b10);
    clks(BUSY - 40);
    chk("R9 still busy", {do_en, do_o}, 2'b10);
    clks(60);
    chk("R9 ready status", {do_en, do_o}, 2'b11);
    bit_out(1);
    chk("R10 one releases", do_en, 0);
    desel();

    wr(8'h21, 16'h1234);
    wr(8'h21, 16'hAAAA);
    wait_ready("R9 ready after ignored");
    rd(8'h21, 0, "R9 ignore", rv); chk("R9 start ignored while busy", rv, 16'h1234);

    wr(8'h22, 16'h0F0F); wait_ready("R8 setup");
    instr(2'b01, 8'h22, 0); send(8'hF0, 8); desel();
    sel(); chk("R8 abort no busy", do_en, 0); desel();
    rd(8'h22, 0, "R8 abort", rv); chk("R8 short write dropped", rv, 16'h0F0F);

    instr(2'b11, 8'h22, 0); desel(); wait_ready("R6 erase ready");
    rd(8'h22, 0, "R6 erase", rv); chk("R6 erase ones", rv, 16'hFFFF);

    ext(2'b01); send(16'h3C5A, 16); desel(); wait_ready("R7 wral ready");
    rd(8'h00, 0, "R7 wral", rv); chk("R7 write-all low", rv, 16'h3C5A);
    rd(8'h7F, 0, "R7 wral", rv); chk("R7 write-all high", rv, 16'h3C5A);

    ext(2'b10); desel(); wait_ready("R6 eral ready");
    rd(8'h45, 0, "R6 eral", rv); chk("R6 erase-all ones", rv, 16'hFFFF);

    org = 0; do_reset();
    ext(2'b11); desel();
    wr(8'hFE, 16'h009B); wait_ready("R3 ready");
    wr(8'h03, 16'h0041); wait_ready("R3 ready");
    rd(8'hFE, 0, "R3 byte read", rv); chk("R3 byte FE", rv, 16'h009B);
    rd(8'h03, 3, "R1 leading zeros", rv); chk("R1 leading zeros ignored", rv, 16'h0041);
    ext(2'b10); desel(); wait_ready("R6 eral x8 ready");
    rd(8'hFE, 0, "R6 eral x8", rv); chk("R6 erase-all x8", rv, 16'h00FF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule